// File: doc/BRIEF.md
# Plug-and-play card configuration port

This block is the card-side half of an indirect configuration scheme on an ISA-style I/O bus. Every card on the bus listens to the same three single-byte ports. An index port at 0x279 takes a register index. A data-write port at 0xA79 takes data. A data-read port sits at a location that software programs at run time. Through these three ports the host reaches a bank of configuration registers that is much larger than the port space.

The card holds a card number. An isolation sequence outside this block delivers that number through a load strobe. The host writes a number to the wake index, and only the card whose number matches stays selected. All later register writes and read-port reads then reach that card alone. Two reserved indices have special roles. Index 0x00 programs the read-port location, and every card accepts it whatever its selection state. Index 0x03 is the wake index. Index 0x40 and the indices above it, up to NREG registers, map onto the card's internal register bank.

Top module: `cfg_port_card`

## Requirements
- R1: After reset no card number is held (0), no card is selected, the register index is 0x00, every bank register is 0x00, the read-port is unprogrammed (no read drives), and rd_drive is low.
- R2: Only writes at exactly 0x279 (index port) and 0xA79 (data-write port) take effect; writes to any other address change no state.
- R3: A write to 0xA79 while the index is 0x00 sets the read-port address to {2'b00, data, 2'b11}, whether the card is selected or not.
- R4: A read-port value outside 0x203..0x3FF (data bit 7 clear) is rejected, and the previous read-port address stays in force.
- R5: A write to 0xA79 while the index is 0x03 selects the card when the data equals its non-zero card number, and deselects it otherwise.
- R6: A card whose number is 0 is never selected and never drives the data bus.
- R7: A write to 0xA79 while the card is selected and the index is 0x40+k (k < NREG) stores the byte in bank register k; the same write while unselected leaves the register unchanged.
- R8: A read at the programmed read-port while selected raises rd_drive for one cycle, in the cycle after the strobe. rd_data then shows bank register k for index 0x40+k, the card number for index 0x03, and 0x00 for any other index.
- R9: A card that is unselected, or a read at any address other than the programmed read-port, leaves rd_drive low.
- R10: A write to 0x279 latches the data byte as the register index in every selection state.
- R11: Loading a card number replaces the stored number and deselects the card.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 12 | I/O address of the current bus cycle |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_wdata | input | 8 | Write data byte |
| csn_load | input | 1 | Load strobe for the card number |
| csn_in | input | 8 | Card number from isolation |
| rd_data | output | 8 | Read data, valid while rd_drive is high |
| rd_drive | output | 1 | Card drives the data bus this cycle |

## Verification
The bench sweeps all 256 wake values against a fixed card number. A wrong comparison would select the card for a foreign or zero number, and the card would then answer a read it should ignore. It also sweeps all 256 read-port bytes and checks that bytes with bit 7 clear leave the old port location answering. A design that accepted those bytes would move the port below 0x203, or would stop answering at the old location. The bench also checks the neighbouring addresses of both fixed ports, register writes made while deselected, a card number of zero, and a card-number reload. Each of these mistakes shows up as a stray write or a bus drive.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] WP_ADDR = 12'hA79;
  localparam logic [ADDR_W-1:0] AP_ADDR = 12'h279;
  localparam logic [ADDR_W-1:0] RP_MIN  = 12'h203;
  localparam logic [ADDR_W-1:0] RP_MAX  = 12'h3FF;
  localparam logic [DATA_W-1:0] IDX_RPORT = 8'h00;
  localparam logic [DATA_W-1:0] IDX_WAKE  = 8'h03;
  localparam logic [DATA_W-1:0] IDX_BANK  = 8'h40;
  typedef logic [ADDR_W-1:0] io_addr_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode
  import cfgp_pkg::*;
(
  input  io_addr_t io_addr,
  input  logic     io_wr,
  input  logic     io_rd,
  input  io_addr_t rp_addr,
  input  logic     rp_valid,
  output logic     wr_wport,
  output logic     wr_aport,
  output logic     rd_rport
);
  always_comb begin
    wr_wport = io_wr && (io_addr == WP_ADDR);
    wr_aport = io_wr && (io_addr == AP_ADDR);
    rd_rport = io_rd && rp_valid && (io_addr == rp_addr);
  end
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
  import cfgp_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  byte_t         wdata,
  input  logic [IW-1:0] ridx,
  output byte_t         rdata
);
  byte_t regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic  en;
    byte_t d;
    always_comb begin
      en = we && (widx == IW'(i));
      d  = en ? wdata : regs_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= '0;
      else        regs_q[i] <= d;
    end
    // R7: a register changes only through its own write enable
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && widx == IW'(i)) |=> $stable(regs_q[i]));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (ridx == IW'(i)) rdata = regs_q[i];
  end
endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
  import cfgp_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_wport,
  input  logic          wr_aport,
  input  logic          rd_rport,
  input  byte_t         io_wdata,
  input  logic          io_rd,
  input  logic          csn_load,
  input  byte_t         csn_in,
  input  byte_t         bank_rdata,
  output io_addr_t      rp_addr,
  output logic          rp_valid,
  output logic          bank_we,
  output logic [IW-1:0] bank_idx,
  output byte_t         rd_data,
  output logic          rd_drive
);
  byte_t    csn_q, csn_d;
  logic     sel_q, sel_d;
  byte_t    idx_q, idx_d;
  io_addr_t rp_q, rp_d;
  logic     rpv_q, rpv_d;
  byte_t    rdat_q, rdat_d;
  logic     drv_q, drv_d;

  io_addr_t cand;
  logic     cand_ok, idx_bank, answer;
  byte_t    rsel;

  always_comb begin
    idx_bank = (int'(idx_q) >= int'(IDX_BANK)) && (int'(idx_q) < int'(IDX_BANK) + NREG);
    bank_idx = IW'(idx_q - IDX_BANK);
    cand     = {2'b00, io_wdata, 2'b11};
    cand_ok  = (cand >= RP_MIN) && (cand <= RP_MAX);
    bank_we  = wr_wport && sel_q && idx_bank;
    answer   = rd_rport && sel_q && (csn_q != '0);
    if (idx_bank)              rsel = bank_rdata;
    else if (idx_q == IDX_WAKE) rsel = csn_q;
    else                        rsel = '0;
  end

  always_comb begin
    csn_d  = csn_q;
    sel_d  = sel_q;
    idx_d  = idx_q;
    rp_d   = rp_q;
    rpv_d  = rpv_q;
    rdat_d = rdat_q;
    drv_d  = answer;
    if (csn_load) begin
      csn_d = csn_in;
      sel_d = 1'b0;
    end else if (wr_wport && idx_q == IDX_WAKE) begin
      sel_d = (csn_q != '0) && (io_wdata == csn_q);
    end
    if (wr_aport) idx_d = io_wdata;
    if (wr_wport && idx_q == IDX_RPORT && cand_ok) begin
      rp_d  = cand;
      rpv_d = 1'b1;
    end
    if (answer) rdat_d = rsel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q  <= '0;
      sel_q  <= 1'b0;
      idx_q  <= IDX_RPORT;
      rp_q   <= '0;
      rpv_q  <= 1'b0;
      rdat_q <= '0;
      drv_q  <= 1'b0;
    end else begin
      csn_q  <= csn_d;
      sel_q  <= sel_d;
      idx_q  <= idx_d;
      rp_q   <= rp_d;
      rpv_q  <= rpv_d;
      rdat_q <= rdat_d;
      drv_q  <= drv_d;
    end
  end

  assign rp_addr  = rp_q;
  assign rp_valid = rpv_q;
  assign rd_data  = rdat_q;
  assign rd_drive = drv_q;

  // R4: a programmed read-port always lies in the legal window
  p_rp_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rpv_q |-> (rp_q >= RP_MIN && rp_q <= RP_MAX));
  // R6: number zero never selected
  p_zero_unsel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_q == '0) |-> !sel_q);
  // R9: drive only after a read strobe on a selected card
  p_drive_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> ($past(sel_q) && $past(io_rd)));
  // R10: index port write latches its byte
  p_idx_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_aport |=> (idx_q == $past(io_wdata)));
  // R11: a load leaves the card deselected
  p_load_desel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    csn_load |=> !sel_q);
endmodule

// File: rtl/cfg_port_card.sv
module cfg_port_card
  import cfgp_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  input  logic        csn_load,
  input  logic [7:0]  csn_in,
  output logic [7:0]  rd_data,
  output logic        rd_drive
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  io_addr_t      rp_addr;
  logic          rp_valid, wr_wport, wr_aport, rd_rport, bank_we;
  logic [IW-1:0] bank_idx;
  byte_t         bank_rdata;

  cfgp_decode u_dec (
    .io_addr (io_addr), .io_wr (io_wr), .io_rd (io_rd),
    .rp_addr (rp_addr), .rp_valid (rp_valid),
    .wr_wport(wr_wport), .wr_aport(wr_aport), .rd_rport(rd_rport)
  );

  cfgp_ctrl #(.NREG(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n),
    .wr_wport(wr_wport), .wr_aport(wr_aport), .rd_rport(rd_rport),
    .io_wdata(io_wdata), .io_rd(io_rd),
    .csn_load(csn_load), .csn_in(csn_in), .bank_rdata(bank_rdata),
    .rp_addr(rp_addr), .rp_valid(rp_valid),
    .bank_we(bank_we), .bank_idx(bank_idx),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  cfgp_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_i_n),
    .we(bank_we), .widx(bank_idx), .wdata(io_wdata),
    .ridx(bank_idx), .rdata(bank_rdata)
  );

  // R2: a write to a foreign address leaves the read path idle next cycle
  p_foreign_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (io_wr && !io_rd && io_addr != WP_ADDR && io_addr != AP_ADDR) |=> !rd_drive);
  // R8: drive lasts one cycle per single strobe
  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_drive && !$past(io_rd, 2)) |=> !rd_drive || $past(io_rd));
endmodule

// File: tb/sim_cfg_port_card.sv
module sim_cfg_port_card;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [11:0] io_addr;
  logic       io_wr, io_rd, csn_load;
  logic [7:0] io_wdata, csn_in, rd_data;
  logic       rd_drive;
  int checks = 0, errors = 0;

  localparam logic [11:0] WP = 12'hA79, AP = 12'h279;
  localparam logic [7:0]  CSN = 8'h5A;

  always #2 clk = ~clk;

  cfg_port_card u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .csn_load(csn_load), .csn_in(csn_in),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic drv, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; drv = rd_drive; d = rd_data;
  endtask

  task automatic load(input logic [7:0] n);
    @(negedge clk); csn_in = n; csn_load = 1'b1;
    @(negedge clk); csn_load = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; io_wr = 0; io_rd = 0; csn_load = 0; io_addr = 0; io_wdata = 0; csn_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wake(input logic [7:0] v);
    wr(AP, 8'h03); wr(WP, v);
  endtask

  initial begin : watchdog
    #700000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic drv; logic [7:0] d; logic [11:0] rp_exp;
    do_reset();
    chk(rd_drive == 1'b0, "R1 drive after reset", rd_drive, 0);
    rd(12'h203, drv, d);
    chk(drv == 1'b0, "R1 unprogrammed port", drv, 0);
    // reset index is 0x00: first data write programs the read-port 0x243
    wr(WP, 8'h90);
    load(CSN);
    wake(CSN);
    wr(AP, 8'h40);
    rd(12'h243, drv, d);
    chk(drv == 1'b1, "R1/R3 reset index programs port", drv, 1);
    chk(d == 8'h00, "R1 bank reset value", d, 0);
    rp_exp = 12'h243;

    // R7/R8: fill bank with a computed pattern, read back
    for (int k = 0; k < 8; k++) begin
      wr(AP, 8'(8'h40 + k)); wr(WP, 8'((k * 37 + 5) & 8'hFF));
    end
    for (int k = 0; k < 8; k++) begin
      wr(AP, 8'(8'h40 + k)); rd(rp_exp, drv, d);
      chk(drv && d == 8'((k * 37 + 5) & 8'hFF), "R7 bank readback", d, (k * 37 + 5) & 8'hFF);
    end
    // R8: wake index reads card number, other index reads 0
    wr(AP, 8'h03); rd(rp_exp, drv, d);
    chk(drv && d == CSN, "R8 wake index value", d, CSN);
    wr(AP, 8'h10); rd(rp_exp, drv, d);
    chk(drv && d == 8'h00, "R8 other index value", d, 0);
    @(negedge clk);
    chk(rd_drive == 1'b0, "R8 single cycle drive", rd_drive, 0);
    rd(12'h244, drv, d);
    chk(drv == 1'b0, "R9 wrong read address", drv, 0);

    // R2: neighbouring addresses ignored
    wr(AP, 8'h41);
    wr(12'h278, 8'h42); wr(12'h27A, 8'h42); wr(12'hA78, 8'hEE); wr(12'hA7A, 8'hEE); wr(12'h679, 8'hEE);
    rd(rp_exp, drv, d);
    chk(drv && d == 8'((1 * 37 + 5) & 8'hFF), "R2 foreign writes ignored", d, 42);

    // R5: sweep all wake values
    for (int v = 0; v < 256; v++) begin
      wake(8'(v)); wr(AP, 8'h40); rd(rp_exp, drv, d);
      chk(drv == (v == CSN), "R5 wake sweep", drv, v == CSN);
    end

    // R7/R9/R10: deselected writes ignored, reads silent, index still latched
    wake(8'h11);
    wr(AP, 8'h42); wr(WP, 8'hC3);
    rd(rp_exp, drv, d);
    chk(drv == 1'b0, "R9 unselected read", drv, 0);
    wake(CSN); wr(AP, 8'h42); rd(rp_exp, drv, d);
    chk(drv && d == 8'((2 * 37 + 5) & 8'hFF), "R7 unselected write ignored", d, 79);
    // R10: index written while deselected takes effect
    wake(8'h00); wr(AP, 8'h43); wr(WP, 8'hFF);
    wr(AP, 8'h03); wr(WP, CSN); wr(AP, 8'h44);
    wake(8'h00); wr(AP, 8'h47); wake(CSN);
    // index is now 0x03 after wake; set via deselected path check
    wake(8'h00); wr(AP, 8'h45);
    load(CSN); wr(AP, 8'h03); wr(WP, CSN);
    rd(rp_exp, drv, d);
    chk(drv && d == CSN, "R10 index latched in any state", d, CSN);

    // R3/R4: sweep all read-port bytes while deselected
    for (int b = 0; b < 256; b++) begin
      wake(8'h00);
      wr(AP, 8'h00); wr(WP, 8'(b));
      if (b >= 8'h80) rp_exp = {2'b00, 8'(b), 2'b11};
      wake(CSN); wr(AP, 8'h40);
      rd(rp_exp, drv, d);
      chk(drv == 1'b1, "R3/R4 port sweep", drv, 1);
      if (b < 8'h80) begin
        rd({2'b00, 8'(b), 2'b11}, drv, d);
        chk(drv == 1'b0, "R4 rejected port", drv, 0);
      end
    end

    // R11: reload deselects
    load(CSN); rd(rp_exp, drv, d);
    chk(drv == 1'b0, "R11 reload deselects", drv, 0);
    // R6: number zero
    load(8'h00); wake(8'h00); wr(AP, 8'h40); rd(rp_exp, drv, d);
    chk(drv == 1'b0, "R6 zero number silent", drv, 0);

    // R1: second reset forgets port and selection
    do_reset();
    load(CSN); wake(CSN); wr(AP, 8'h40);
    rd(rp_exp, drv, d);
    chk(drv == 1'b0, "R1 port cleared by reset", drv, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule